// File: doc/BRIEF.md
# Arbiter Slot Table Builder

This engine fills a time-slot table for a memory arbiter. Each table entry names the client that owns one arbitration slot. The engine takes a slot request count and an active flag for each client, a count of clients in use, and a count of spare slots that may go to clients asking for nothing. It places the entries in three passes and then sends them out in slot order.

The first pass works through the clients from the lowest index up. Each client that asks for slots gets entries spread at a fixed spacing. The second part of that pass gives a single entry to each active client whose request is zero, while spare slots remain. The last pass fills every entry still empty. It hands these out round-robin to the active clients, using a pointer that carries over from one entry to the next.

The input configuration is captured on a `start` pulse. The table goes out on a valid/ready stream. An entry moves only on a cycle where `out_valid` and `out_ready` are both high. While `out_ready` is low, the slot index and client value stay frozen, and a consumer may hold it low for as long as it needs. A request set whose total is over the table size is refused at `start`.

Top module: `slot_tbl_builder`

## Requirements
- R1: After reset, `out_valid`, `done`, `reject` and `busy` are all low.
- R2: Before placement, every entry is empty. Clients `0` to `num_clients-1` are handled in ascending order. A client asking for N>0 slots gets stride NSLOT/N (integer division, at least 1). Its scan starts at entry 0. A taken entry moves the scan forward by 1. A free entry is given to the client and moves the scan forward by the stride. The scan stops once the position reaches NSLOT.
- R3: A client with a non-zero request is placed whether or not its active flag is set.
- R4: An active client with a zero request gets exactly one entry, using stride NSLOT, only while the spare count (captured from `free_slots`) is above zero. Each such grant lowers the spare count by one. Inactive zero-request clients are skipped, and so are zero-request clients once the spare count is zero.
- R5: Each entry still empty after placement gets the next active client at or after a round-robin pointer. The pointer starts at 0, wraps at `num_clients`, and moves to the chosen client plus one. It moves only on empty entries.
- R6: If no client below `num_clients` is active, an empty entry gets the pointer value itself, and the pointer still advances by one with wrap.
- R7: Entries are sent in order, from slot 0 to slot NSLOT-1, one per handshake. While `out_valid` is high and `out_ready` is low, `out_slot` and `out_client` hold steady.
- R8: `done` is high for exactly one cycle, the cycle right after the handshake of slot NSLOT-1. `out_valid` is low in that cycle.
- R9: If the requests of clients below `num_clients` add up to more than NSLOT at `start`, `reject` pulses for one cycle, and no table is built or sent.
- R10: A `start` pulse while `busy` is high is ignored. The table being sent is unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Capture the configuration and build a table (only while idle) |
| req_cnt | input | NCLI*RW | Requested slot count per client; client i is at bits [i*RW +: RW] |
| active | input | NCLI | Active flag per client |
| num_clients | input | CLW | Number of clients taking part |
| free_slots | input | RW | Spare slots that may go to zero-request clients |
| out_valid | output | 1 | A table entry is offered |
| out_ready | input | 1 | The consumer accepts the offered entry |
| out_slot | output | SIW | Slot index of the offered entry |
| out_client | output | CIW | Client that owns the offered slot |
| done | output | 1 | One-cycle pulse after the last entry is accepted |
| reject | output | 1 | One-cycle pulse: the request total is over the table size |
| busy | output | 1 | A build or a stream is in progress |

## Verification
The bench builds the engine with a 16-entry table and 5 clients.

At that size, a sweep can reach every active mask and every client count from 1 to 5. It also covers spare counts from 0 to 3 and a wide spread of request patterns, including full tables, request totals over the limit and masks with no active client.

Each resulting table is compared entry by entry against placement arithmetic done in the bench. The consumer stalls in varying patterns throughout. Some runs also inject a start pulse in the middle of the stream.

// File: rtl/slot_tbl_pkg.sv
package slot_tbl_pkg;
  typedef enum logic [1:0] {
    PH_IDLE   = 2'd0,
    PH_PLACE  = 2'd1,
    PH_STREAM = 2'd2,
    PH_DONE   = 2'd3
  } phase_t;
endpackage

// File: rtl/slot_tbl_store.sv
module slot_tbl_store #(
  parameter int NSLOT = 64,
  parameter int CIW   = 4,
  localparam int SIW  = $clog2(NSLOT)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           clr,
  input  logic           wr_en,
  input  logic [SIW-1:0] wr_idx,
  input  logic [CIW-1:0] wr_cli,
  input  logic [SIW-1:0] a_idx,
  output logic           a_used,
  input  logic [SIW-1:0] b_idx,
  output logic           b_used,
  output logic [CIW-1:0] b_cli
);
  logic           used_q [NSLOT];
  logic [CIW-1:0] cli_q  [NSLOT];

  for (genvar e = 0; e < NSLOT; e++) begin : g_ent
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        used_q[e] <= 1'b0;
        cli_q[e]  <= '0;
      end else if (clr) begin
        used_q[e] <= 1'b0;
      end else if (wr_en && wr_idx == SIW'(e)) begin
        used_q[e] <= 1'b1;
        cli_q[e]  <= wr_cli;
      end
    end
  end

  assign a_used = used_q[a_idx];
  assign b_used = used_q[b_idx];
  assign b_cli  = cli_q[b_idx];
endmodule

// File: rtl/slot_rr_pick.sv
module slot_rr_pick #(
  parameter int NCLI = 16,
  localparam int CIW = $clog2(NCLI),
  localparam int CLW = $clog2(NCLI+1)
) (
  input  logic [NCLI-1:0] act,
  input  logic [CLW-1:0]  num,
  input  logic [CIW-1:0]  ptr,
  output logic [CIW-1:0]  pick,
  output logic [CIW-1:0]  nxt
);
  logic found;

  always_comb begin
    pick  = ptr;
    found = 1'b0;
    for (int k = 0; k < NCLI; k++) begin
      int idx;
      idx = int'(ptr) + k;
      if (idx >= int'(num)) idx = idx - int'(num);
      if (!found && k < int'(num) && idx < NCLI && idx >= 0) begin
        if (act[idx]) begin
          pick  = CIW'(idx);
          found = 1'b1;
        end
      end
    end
    if (int'(pick) + 1 >= int'(num)) nxt = '0;
    else                             nxt = pick + 1'b1;
  end
endmodule

// File: rtl/slot_placer.sv
module slot_placer #(
  parameter int NSLOT = 64,
  parameter int NCLI  = 16,
  localparam int RW   = $clog2(NSLOT) + 1,
  localparam int SIW  = $clog2(NSLOT),
  localparam int PW   = SIW + 1,
  localparam int CIW  = $clog2(NCLI),
  localparam int CLW  = $clog2(NCLI+1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              go,
  input  logic [NCLI*RW-1:0] req_flat,
  input  logic [NCLI-1:0]   act,
  input  logic [CLW-1:0]    num,
  input  logic [RW-1:0]     free_in,
  output logic [SIW-1:0]    a_idx,
  input  logic              a_used,
  output logic              wr_en,
  output logic [SIW-1:0]    wr_idx,
  output logic [CIW-1:0]    wr_cli,
  output logic              fin
);
  logic          run_q, scan_q;
  logic [CLW-1:0] c_q;
  logic [PW-1:0]  p_q, stride_q, stride_c;
  logic [RW-1:0]  spare_q, req_c;
  logic           act_c;

  always_comb begin
    req_c = '0;
    act_c = 1'b0;
    for (int i = 0; i < NCLI; i++) begin
      if (CLW'(i) == c_q) begin
        req_c = req_flat[i*RW +: RW];
        act_c = act[i];
      end
    end
  end

  always_comb begin
    int q;
    q = NSLOT;
    if (req_c != '0) begin
      q = NSLOT / int'(req_c);
      if (q < 1) q = 1;
    end
    stride_c = PW'(q);
  end

  assign a_idx  = p_q[SIW-1:0];
  assign wr_idx = p_q[SIW-1:0];
  assign wr_cli = c_q[CIW-1:0];
  assign wr_en  = run_q && scan_q && (p_q < PW'(NSLOT)) && !a_used;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q    <= 1'b0;
      scan_q   <= 1'b0;
      c_q      <= '0;
      p_q      <= '0;
      stride_q <= '0;
      spare_q  <= '0;
      fin      <= 1'b0;
    end else begin
      fin <= 1'b0;
      if (go) begin
        run_q   <= 1'b1;
        scan_q  <= 1'b0;
        c_q     <= '0;
        spare_q <= free_in;
      end else if (run_q) begin
        if (!scan_q) begin
          if (c_q >= num) begin
            run_q <= 1'b0;
            fin   <= 1'b1;
          end else if (req_c != '0) begin
            scan_q   <= 1'b1;
            p_q      <= '0;
            stride_q <= stride_c;
          end else if (act_c && spare_q != '0) begin
            spare_q  <= spare_q - 1'b1;
            scan_q   <= 1'b1;
            p_q      <= '0;
            stride_q <= PW'(NSLOT);
          end else begin
            c_q <= c_q + 1'b1;
          end
        end else if (p_q >= PW'(NSLOT)) begin
          scan_q <= 1'b0;
          c_q    <= c_q + 1'b1;
        end else if (a_used) begin
          p_q <= p_q + 1'b1;
        end else begin
          p_q <= p_q + stride_q;
        end
      end
    end
  end
endmodule

// File: rtl/slot_tbl_builder.sv
module slot_tbl_builder
  import slot_tbl_pkg::*;
#(
  parameter int NSLOT = 64,
  parameter int NCLI  = 16,
  localparam int RW   = $clog2(NSLOT) + 1,
  localparam int SIW  = $clog2(NSLOT),
  localparam int CIW  = $clog2(NCLI),
  localparam int CLW  = $clog2(NCLI+1)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start,
  input  logic [NCLI*RW-1:0] req_cnt,
  input  logic [NCLI-1:0]    active,
  input  logic [CLW-1:0]     num_clients,
  input  logic [RW-1:0]      free_slots,
  output logic               out_valid,
  input  logic               out_ready,
  output logic [SIW-1:0]     out_slot,
  output logic [CIW-1:0]     out_client,
  output logic               done,
  output logic               reject,
  output logic               busy
);
  localparam int SW = RW + CLW;

  phase_t             ph_q;
  logic [NCLI*RW-1:0] req_q;
  logic [NCLI-1:0]    act_q;
  logic [CLW-1:0]     num_q;
  logic [SIW-1:0]     slot_q;
  logic [CIW-1:0]     ptr_q, pick, nxt;
  logic [SW-1:0]      total;
  logic               over, go, fin;
  logic               a_used, b_used, wr_en;
  logic [SIW-1:0]     a_idx, wr_idx;
  logic [CIW-1:0]     wr_cli, b_cli;

  always_comb begin
    total = '0;
    for (int i = 0; i < NCLI; i++)
      if (CLW'(i) < num_clients) total = total + SW'(req_cnt[i*RW +: RW]);
  end
  assign over = total > SW'(NSLOT);
  assign go   = start && (ph_q == PH_IDLE) && !over;

  slot_tbl_store #(.NSLOT(NSLOT), .CIW(CIW)) u_store (
    .clk(clk), .rst_n(rst_n), .clr(go),
    .wr_en(wr_en), .wr_idx(wr_idx), .wr_cli(wr_cli),
    .a_idx(a_idx), .a_used(a_used),
    .b_idx(slot_q), .b_used(b_used), .b_cli(b_cli)
  );

  slot_placer #(.NSLOT(NSLOT), .NCLI(NCLI)) u_place (
    .clk(clk), .rst_n(rst_n), .go(go),
    .req_flat(req_q), .act(act_q), .num(num_q), .free_in(free_slots),
    .a_idx(a_idx), .a_used(a_used),
    .wr_en(wr_en), .wr_idx(wr_idx), .wr_cli(wr_cli), .fin(fin)
  );

  slot_rr_pick #(.NCLI(NCLI)) u_pick (
    .act(act_q), .num(num_q), .ptr(ptr_q), .pick(pick), .nxt(nxt)
  );

  assign out_valid  = (ph_q == PH_STREAM);
  assign out_slot   = slot_q;
  assign out_client = b_used ? b_cli : pick;
  assign done       = (ph_q == PH_DONE);
  assign busy       = (ph_q != PH_IDLE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_q   <= PH_IDLE;
      req_q  <= '0;
      act_q  <= '0;
      num_q  <= '0;
      slot_q <= '0;
      ptr_q  <= '0;
      reject <= 1'b0;
    end else begin
      reject <= 1'b0;
      case (ph_q)
        PH_IDLE: begin
          if (start && over) reject <= 1'b1;
          if (go) begin
            req_q <= req_cnt;
            act_q <= active;
            num_q <= num_clients;
            ph_q  <= PH_PLACE;
          end
        end
        PH_PLACE: begin
          if (fin) begin
            ph_q   <= PH_STREAM;
            slot_q <= '0;
            ptr_q  <= '0;
          end
        end
        PH_STREAM: begin
          if (out_ready) begin
            if (!b_used) ptr_q <= nxt;
            if (slot_q == SIW'(NSLOT-1)) ph_q <= PH_DONE;
            else                         slot_q <= slot_q + 1'b1;
          end
        end
        default: ph_q <= PH_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/slot_tbl_builder_chk.sv
module slot_tbl_builder_chk #(
  parameter int NSLOT = 64,
  parameter int SIW   = 6,
  parameter int CIW   = 4,
  parameter int CLW   = 5
) (
  input logic           clk,
  input logic           rst_n,
  input logic           out_valid,
  input logic           out_ready,
  input logic [SIW-1:0] out_slot,
  input logic [CIW-1:0] out_client,
  input logic           done,
  input logic           reject,
  input logic           busy,
  input logic [CLW-1:0] num_q
);
  // R7
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_slot) && $stable(out_client));
  // R7
  slot_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_ready && out_slot != SIW'(NSLOT-1)
      |=> out_valid && out_slot == SIW'($past(out_slot) + 1'b1));
  // R7
  first_slot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(out_valid) |-> out_slot == '0);
  // R8
  done_after_last_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_ready && out_slot == SIW'(NSLOT-1) |=> done && !out_valid);
  // R8
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  // R9
  reject_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    reject |-> !busy && !out_valid);
  // R1
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !out_valid && !done);
  // R5
  client_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && num_q != '0 |-> CLW'(out_client) < num_q);
endmodule

bind slot_tbl_builder slot_tbl_builder_chk #(
  .NSLOT(NSLOT), .SIW(SIW), .CIW(CIW), .CLW(CLW)
) u_chk (
  .clk(clk), .rst_n(rst_n), .out_valid(out_valid), .out_ready(out_ready),
  .out_slot(out_slot), .out_client(out_client), .done(done),
  .reject(reject), .busy(busy), .num_q(num_q)
);

// File: tb/slot_tbl_builder_tb.sv
module slot_tbl_builder_tb;
  localparam int NS  = 16;
  localparam int NC  = 5;
  localparam int RW  = $clog2(NS) + 1;
  localparam int SIW = $clog2(NS);
  localparam int CIW = $clog2(NC);
  localparam int CLW = $clog2(NC+1);

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             start = 1'b0;
  logic [NC*RW-1:0] req_cnt = '0;
  logic [NC-1:0]    active = '0;
  logic [CLW-1:0]   num_clients = '0;
  logic [RW-1:0]    free_slots = '0;
  logic             out_valid, out_ready, done, reject, busy;
  logic [SIW-1:0]   out_slot;
  logic [CIW-1:0]   out_client;

  always #2 clk = ~clk;

  slot_tbl_builder #(.NSLOT(NS), .NCLI(NC)) u_dut (
    .clk(clk), .rst_n(rst_n), .start(start), .req_cnt(req_cnt),
    .active(active), .num_clients(num_clients), .free_slots(free_slots),
    .out_valid(out_valid), .out_ready(out_ready), .out_slot(out_slot),
    .out_client(out_client), .done(done), .reject(reject), .busy(busy)
  );

  int n_chk = 0, n_fail = 0;
  int r_req[NC];
  int r_act[NC];
  int r_num, r_free;
  int ref_tbl[NS];
  int unsigned seed = 32'h1234_5678;
  int cyc = 0;

  task automatic chk(input bit ok, input string tag, input int actv, input int expv);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, actv, expv);
    end
  endtask

  function automatic int rnd(input int m);
    seed = seed * 32'd1103515245 + 32'd12345;
    return int'((seed >> 16) % m);
  endfunction

  // R2 R3 R4 R5 R6: expected table from the placement rules
  task automatic build_ref();
    int fr, ptr;
    fr = r_free;
    for (int s = 0; s < NS; s++) ref_tbl[s] = -1;
    for (int c = 0; c < r_num; c++) begin
      int stride, pos;
      if (r_req[c] == 0) begin
        if (r_act[c] == 0 || fr <= 0) continue;
        fr--;
        stride = NS;
      end else begin
        stride = NS / r_req[c];
        if (stride < 1) stride = 1;
      end
      pos = 0;
      while (pos < NS) begin
        if (ref_tbl[pos] >= 0) pos++;
        else begin
          ref_tbl[pos] = c;
          pos += stride;
        end
      end
    end
    ptr = 0;
    for (int s = 0; s < NS; s++) begin
      if (ref_tbl[s] < 0) begin
        int first;
        first = ptr;
        while (r_act[ptr] == 0) begin
          ptr = (ptr + 1) % r_num;
          if (ptr == first) break;
        end
        ref_tbl[s] = ptr;
        ptr = (ptr + 1) % r_num;
      end
    end
  endtask

  task automatic drive_cfg();
    for (int c = 0; c < NC; c++) begin
      req_cnt[c*RW +: RW] = RW'(r_req[c]);
      active[c] = (r_act[c] != 0);
    end
    num_clients = CLW'(r_num);
    free_slots  = RW'(r_free);
  endtask

  task automatic run_case(input int run, input bit inject);
    int sum, idx, guard;
    bit injected;
    sum = 0;
    for (int c = 0; c < r_num; c++) sum += r_req[c];
    drive_cfg();
    @(negedge clk);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    if (sum > NS) begin
      chk(reject == 1'b1, "R9 reject pulse", int'(reject), 1);
      @(negedge clk);
      chk(reject == 1'b0 && busy == 1'b0 && out_valid == 1'b0,
          "R9 no build after reject", int'(busy), 0);
      return;
    end
    chk(reject == 1'b0 && busy == 1'b1, "R9 accepted start", int'(busy), 1);
    build_ref();
    idx = 0;
    guard = 0;
    injected = 1'b0;
    while (1) begin
      @(negedge clk);
      start = 1'b0;
      guard++;
      if (idx == NS) begin
        chk(done == 1'b1 && out_valid == 1'b0, "R8 done after last entry", int'(done), 1);
        @(negedge clk);
        chk(done == 1'b0 && busy == 1'b0, "R8 done one cycle", int'(done), 0);
        break;
      end
      if (done) begin
        chk(1'b0, "R8 early done", idx, NS);
        break;
      end
      if (guard > 4000) begin
        chk(1'b0, "R7 stream stalled", idx, NS);
        break;
      end
      if (inject && !injected && idx == 3 && out_valid) begin
        // R10: start during streaming with another mask
        start = 1'b1;
        active = ~active;
        injected = 1'b1;
      end
      out_ready = (run % 3 == 0) ? 1'b1 : (((cyc * 7 + run) % 5) != 0);
      if (out_valid && out_ready) begin
        chk(int'(out_slot) == idx, "R7 slot order", int'(out_slot), idx);
        chk(int'(out_client) == ref_tbl[idx],
            inject ? "R10 table kept after busy start" : "R2/R5 entry value",
            int'(out_client), ref_tbl[idx]);
        idx++;
      end
    end
    out_ready = 1'b0;
  endtask

  always @(posedge clk) cyc <= cyc + 1;

  initial begin
    out_ready = 1'b0;
    repeat (3) @(negedge clk);
    // R1
    chk(out_valid == 1'b0 && done == 1'b0 && reject == 1'b0 && busy == 1'b0,
        "R1 reset state", int'(busy), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(out_valid == 1'b0 && busy == 1'b0, "R1 idle after reset", int'(out_valid), 0);

    for (int run = 0; run < 320; run++) begin
      r_num  = 1 + (run % NC);
      r_free = (run / 7) % 4;
      for (int c = 0; c < NC; c++) begin
        int v;
        r_act[c] = (run >> c) & 1;
        v = rnd(4);
        r_req[c] = (v == 0) ? 0 : (v == 1) ? 1 : (v == 2) ? 2 : rnd(6);
      end
      if (run == 0) begin
        // R6: nothing active, nothing requested
        for (int c = 0; c < NC; c++) begin r_act[c] = 0; r_req[c] = 0; end
        r_num = 4;
      end else if (run == 1) begin
        // R3: one inactive client owns the full table
        for (int c = 0; c < NC; c++) begin r_act[c] = 0; r_req[c] = 0; end
        r_req[2] = NS; r_num = NC;
      end else if (run == 2) begin
        // R4: all zero requests, spare count limits grants
        for (int c = 0; c < NC; c++) begin r_act[c] = 1; r_req[c] = 0; end
        r_free = 2; r_num = NC;
      end else if (run == 3) begin
        // R9: total one above the table size
        for (int c = 0; c < NC; c++) r_req[c] = 0;
        r_req[0] = 9; r_req[1] = 8; r_num = 2;
      end
      run_case(run, (run % 11) == 5);
    end
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    #800000;
    n_chk++;
    n_fail++;
    $display("FAIL watchdog expired actual=%0d expected=0", cyc);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule